// File: doc/BRIEF.md
# Serial Two-Smallest Positive Value Tracker

This block watches a row of signed samples that arrive one per clock on a valid-qualified stream. It keeps the smallest and the second-smallest strictly positive values of the row, along with the zero-based position of each. Zero and negative samples are skipped. The position of a sample is the number of accepted samples in front of it in the same row.

A row opens with a start marker and closes with an end marker. When the closing sample is accepted, the block publishes both values, both positions and two flags that say whether each result exists. A one-cycle done pulse marks the update. Each accepted sample takes one clock and at most two magnitude comparisons, so a row of N samples is resolved in N cycles, plus one register stage to publish.

Top module: `pair_min_scan`

## Requirements
- R1: A sample takes part only when `in_valid` is 1 and its value, read as signed two's complement, is greater than zero. Zero samples, negative samples and cycles with `in_valid` at 0 change no result, and the start and end markers are ignored on a cycle with `in_valid` at 0.
- R2: At row close, `out_min1` is the smallest qualifying value of the row and `out_pos1` is its zero-based position. Positions count accepted samples (`in_valid` at 1) from 0 at the row's first sample, and invalid cycles do not advance the count.
- R3: At row close, `out_min2` is the smallest qualifying value that is left once the sample reported as the minimum is removed, and `out_pos2` is its position. A second sample equal to the minimum is therefore reported as `out_min2`.
- R4: Among equal values the earlier position wins. A sample equal to the current minimum takes second place only when it is strictly smaller than the current second value.
- R5: `out_min1_ok` is 1 when at least one sample of the row qualified. `out_min2_ok` is 1 when at least two qualified. A result that does not exist reads as the largest positive value 2^(DATA_W-1)-1, with position 0.
- R6: `out_done` is 1 for exactly one cycle, on the clock after a sample with `in_last` at 1 is accepted. All result outputs change only at that edge and hold their values until the next row closes.
- R7: An accepted sample with `in_first` at 1 throws away any partial tracking and takes position 0. After a row closes, the next accepted sample also takes position 0, even without a start marker.
- R8: While reset is held and after it is released, `out_done` and both flags are 0, both values are 2^(DATA_W-1)-1 and both positions are 0.
- R9: A qualifying sample equal to the largest positive value is tracked like any other value. It sets the matching flag and records its own position.
- R10: Rows may follow back to back, with the next row's first sample on the cycle right after the previous row's last sample. Each row's results match that row alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present this cycle |
| in_first | input | 1 | Sample opens a new row |
| in_last | input | 1 | Sample closes the row |
| in_data | input | DATA_W | Signed sample value |
| out_done | output | 1 | One-cycle pulse when results are published |
| out_min1 | output | DATA_W | Smallest qualifying value |
| out_pos1 | output | IDX_W | Position of the smallest value |
| out_min1_ok | output | 1 | Smallest value exists |
| out_min2 | output | DATA_W | Second-smallest qualifying value |
| out_pos2 | output | IDX_W | Position of the second-smallest value |
| out_min2_ok | output | 1 | Second-smallest value exists |

## Verification
Every possible four-sample row over 3-bit signed values is driven through the block, so rows with no, one, two or more positive samples, duplicated minima, a repeated top value and mixes of zeros and negatives are all covered. These rows separate the strict and non-strict comparisons and the earlier-position rule. On half of the rows, an invalid cycle that carries both markers and a positive value is slipped in mid-row. That cycle must neither count as a position nor restart or close the row. Directed rows cover three more cases: a restart in the middle of a row, a row with no start marker after a close, and two rows sent back to back. These separate the restart path from the close path, and show that each row's results stay apart from the next row's.

// File: rtl/pms_pkg.sv
package pms_pkg;

    // Action chosen by the ranking unit for one qualifying sample.
    typedef enum logic [1:0] {
        UPD_KEEP   = 2'd0,
        UPD_SECOND = 2'd1,
        UPD_SHIFT  = 2'd2
    } upd_e;

    // Width of a position index for a row of n samples (at least 1 bit).
    function automatic int idx_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pms_qualify.sv
module pms_qualify #(
    parameter int DATA_W = 16
) (
    input  logic                     valid_i,
    input  logic signed [DATA_W-1:0] sample_i,
    output logic                     keep_o
);

    // Strictly positive: sign bit clear and not all zero.
    always_comb begin
        keep_o = valid_i && !sample_i[DATA_W-1] && (sample_i != '0);
    end

endmodule

// File: rtl/pms_rank.sv
module pms_rank #(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] sample_i,
    input  logic                     have1_i,
    input  logic signed [DATA_W-1:0] best_i,
    input  logic                     have2_i,
    input  logic signed [DATA_W-1:0] second_i,
    output pms_pkg::upd_e            act_o
);

    logic beats_best;
    logic beats_second;

    // Empty slots count as infinity, so a sample at the maximum value still lands.
    always_comb begin
        beats_best   = !have1_i || (sample_i < best_i);
        beats_second = !have2_i || (sample_i < second_i);
        if (beats_best) begin
            act_o = pms_pkg::UPD_SHIFT;
        end else if (beats_second) begin
            act_o = pms_pkg::UPD_SECOND;
        end else begin
            act_o = pms_pkg::UPD_KEEP;
        end
    end

endmodule

// File: rtl/pms_index.sv
module pms_index #(
    parameter int ROW_LEN = 64,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             restart_i,
    input  logic             close_i,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(ROW_LEN - 1);

    logic [IDX_W-1:0] cnt_d;
    logic [IDX_W-1:0] cnt_q;

    always_comb begin
        idx_o = restart_i ? '0 : cnt_q;
        cnt_d = cnt_q;
        if (step_i) begin
            if (close_i || (idx_o == IDX_TOP)) begin
                cnt_d = '0;
            end else begin
                cnt_d = idx_o + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/pair_min_scan.sv
module pair_min_scan #(
    parameter int DATA_W  = 16,
    parameter int ROW_LEN = 64,
    localparam int IDX_W  = pms_pkg::idx_width(ROW_LEN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_first,
    input  logic                     in_last,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_done,
    output logic signed [DATA_W-1:0] out_min1,
    output logic [IDX_W-1:0]         out_pos1,
    output logic                     out_min1_ok,
    output logic signed [DATA_W-1:0] out_min2,
    output logic [IDX_W-1:0]         out_pos2,
    output logic                     out_min2_ok
);

    localparam logic [DATA_W-1:0] INF = {1'b0, {(DATA_W-1){1'b1}}};

    typedef struct packed {
        logic [DATA_W-1:0] min1;
        logic [IDX_W-1:0]  pos1;
        logic              ok1;
        logic [DATA_W-1:0] min2;
        logic [IDX_W-1:0]  pos2;
        logic              ok2;
    } pair_t;

    typedef struct packed {
        pair_t trk;
        pair_t res;
        logic  done;
    } state_t;

    localparam pair_t PAIR_EMPTY = '{
        min1: INF, pos1: '0, ok1: 1'b0,
        min2: INF, pos2: '0, ok2: 1'b0
    };

    state_t st_d;
    state_t st_q;

    logic             keep;
    logic             restart;
    logic             close;
    logic [IDX_W-1:0] idx;
    pair_t            base;
    pair_t            nxt;
    pms_pkg::upd_e    act;

    assign restart = in_valid && in_first;
    assign close   = in_valid && in_last;

    pms_qualify #(.DATA_W(DATA_W)) qual_i (
        .valid_i  (in_valid),
        .sample_i (in_data),
        .keep_o   (keep)
    );

    pms_index #(.ROW_LEN(ROW_LEN), .IDX_W(IDX_W)) index_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (in_valid),
        .restart_i (restart),
        .close_i   (close),
        .idx_o     (idx)
    );

    // Tracking state seen by this sample: cleared when the sample opens a row.
    always_comb begin
        base = restart ? PAIR_EMPTY : st_q.trk;
    end

    pms_rank #(.DATA_W(DATA_W)) rank_i (
        .sample_i (in_data),
        .have1_i  (base.ok1),
        .best_i   (base.min1),
        .have2_i  (base.ok2),
        .second_i (base.min2),
        .act_o    (act)
    );

    always_comb begin
        nxt = base;
        if (keep) begin
            unique case (act)
                pms_pkg::UPD_SHIFT: begin
                    nxt.min2 = base.min1;
                    nxt.pos2 = base.pos1;
                    nxt.ok2  = base.ok1;
                    nxt.min1 = in_data;
                    nxt.pos1 = idx;
                    nxt.ok1  = 1'b1;
                end
                pms_pkg::UPD_SECOND: begin
                    nxt.min2 = in_data;
                    nxt.pos2 = idx;
                    nxt.ok2  = 1'b1;
                end
                default: begin
                    nxt = base;
                end
            endcase
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (in_valid) begin
            if (in_last) begin
                st_d.res  = nxt;
                st_d.done = 1'b1;
                st_d.trk  = PAIR_EMPTY;
            end else begin
                st_d.trk  = nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{trk: PAIR_EMPTY, res: PAIR_EMPTY, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_done    = st_q.done;
    assign out_min1    = st_q.res.min1;
    assign out_pos1    = st_q.res.pos1;
    assign out_min1_ok = st_q.res.ok1;
    assign out_min2    = st_q.res.min2;
    assign out_pos2    = st_q.res.pos2;
    assign out_min2_ok = st_q.res.ok2;

endmodule

// File: rtl/pms_checker.sv
module pms_checker #(
    parameter int DATA_W  = 16,
    parameter int ROW_LEN = 64,
    parameter int IDX_W   = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_first,
    input logic                     in_last,
    input logic signed [DATA_W-1:0] in_data,
    input logic                     out_done,
    input logic signed [DATA_W-1:0] out_min1,
    input logic [IDX_W-1:0]         out_pos1,
    input logic                     out_min1_ok,
    input logic signed [DATA_W-1:0] out_min2,
    input logic [IDX_W-1:0]         out_pos2,
    input logic                     out_min2_ok
);

    localparam logic signed [DATA_W-1:0] TOP = {1'b0, {(DATA_W-1){1'b1}}};

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> out_done); // R6

    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> $past(in_valid && in_last)); // R6

    AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_done |-> ($stable(out_min1) && $stable(out_pos1) && $stable(out_min1_ok)
                       && $stable(out_min2) && $stable(out_pos2) && $stable(out_min2_ok))); // R6

    AST_FLAG_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_min2_ok |-> out_min1_ok); // R5

    AST_ABSENT_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        !out_min1_ok |-> (out_min1 == TOP && out_pos1 == '0)); // R5

    AST_ONLY_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_min1_ok |-> (out_min1 > 0)); // R1

    AST_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        out_min2_ok |-> (out_min1 <= out_min2)); // R3

    AST_DISTINCT_POS: assert property (@(posedge clk) disable iff (!rst_n)
        out_min2_ok |-> (out_pos1 != out_pos2)); // R3

    AST_TIE_EARLIER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_min2_ok && out_min1 == out_min2) |-> (out_pos1 < out_pos2)); // R4

endmodule

bind pair_min_scan pms_checker #(
    .DATA_W  (DATA_W),
    .ROW_LEN (ROW_LEN),
    .IDX_W   (IDX_W)
) chk_i (.*);

// File: tb/pair_min_scan_tb.sv
module pair_min_scan_tb_top;

    localparam int DW  = 3;
    localparam int RL  = 4;
    localparam int IW  = 2;
    localparam int TOP = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_first = 1'b0;
    logic                 in_last = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic                 out_done;
    logic signed [DW-1:0] out_min1;
    logic [IW-1:0]        out_pos1;
    logic                 out_min1_ok;
    logic signed [DW-1:0] out_min2;
    logic [IW-1:0]        out_pos2;
    logic                 out_min2_ok;

    int tests  = 0;
    int failed = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pair_min_scan #(.DATA_W(DW), .ROW_LEN(RL)) dut_i (
        .clk, .rst_n, .in_valid, .in_first, .in_last, .in_data,
        .out_done, .out_min1, .out_pos1, .out_min1_ok,
        .out_min2, .out_pos2, .out_min2_ok
    );

    task automatic chk(input bit good, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!good) begin
            failed++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put(input int v, input bit f, input bit l, input bit vld);
        @(negedge clk);
        in_valid = vld;
        in_first = f;
        in_last  = l;
        in_data  = DW'(v);
    endtask

    // Two-pass model: first the minimum, then the minimum of what remains.
    task automatic compare(input int vals[RL], input int n, input string req);
        int m1 = TOP, p1 = 0, m2 = TOP, p2 = 0;
        bit o1 = 0, o2 = 0;
        for (int j = 0; j < n; j++) begin
            if (vals[j] > 0 && (!o1 || vals[j] < m1)) begin
                m1 = vals[j]; p1 = j; o1 = 1;
            end
        end
        for (int j = 0; j < n; j++) begin
            if (o1 && j != p1 && vals[j] > 0 && (!o2 || vals[j] < m2)) begin
                m2 = vals[j]; p2 = j; o2 = 1;
            end
        end
        chk(out_done == 1'b1, "R6", "done pulse", int'(out_done), 1);
        chk(int'(out_min1) == m1 && int'(out_pos1) == p1, req, "min1/pos1 (R2)",
            int'(out_min1) * 10 + int'(out_pos1), m1 * 10 + p1);
        chk(int'(out_min2) == m2 && int'(out_pos2) == p2, req, "min2/pos2 (R3 R4)",
            int'(out_min2) * 10 + int'(out_pos2), m2 * 10 + p2);
        chk(out_min1_ok == o1 && out_min2_ok == o2, "R5", "ok flags",
            int'({out_min1_ok, out_min2_ok}), int'({o1, o2}));
    endtask

    // Next negedge after the last sample: check, then one more cycle for hold.
    task automatic close_row(input int vals[RL], input int n, input string req);
        logic [DW-1:0] h1, h2;
        logic [IW-1:0] q1, q2;
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
        compare(vals, n, req);
        h1 = out_min1; h2 = out_min2; q1 = out_pos1; q2 = out_pos2;
        @(negedge clk);
        chk(out_done == 1'b0, "R6", "done lasts one cycle", int'(out_done), 0);
        chk(out_min1 == h1 && out_min2 == h2 && out_pos1 == q1 && out_pos2 == q2,
            "R6", "results hold", int'({out_min1, out_min2}), int'({h1, h2}));
    endtask

    initial begin
        int v[RL];
        repeat (3) @(negedge clk);
        chk(out_done == 0 && out_min1_ok == 0 && out_min2_ok == 0, "R8", "reset flags",
            int'({out_done, out_min1_ok, out_min2_ok}), 0);
        chk(int'(out_min1) == TOP && int'(out_min2) == TOP && out_pos1 == 0 && out_pos2 == 0,
            "R8", "reset values", int'(out_min1), TOP);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_done == 0 && int'(out_min1) == TOP && !out_min1_ok, "R8", "after release",
            int'(out_min1), TOP);

        // Sweep every row of four 3-bit signed samples (R1 R2 R3 R4 R5 R9).
        for (int code = 0; code < 4096; code++) begin
            for (int k = 0; k < RL; k++) begin
                int s = (code >> (3 * k)) & 7;
                v[k] = (s >= 4) ? s - 8 : s;
            end
            for (int k = 0; k < RL; k++) begin
                put(v[k], k == 0, k == RL - 1, 1'b1);
                if (k == 1 && code[0]) put(1, 1'b1, 1'b1, 1'b0); // R1 invalid gap, R10
            end
            close_row(v, RL, "R2");
        end

        // Example row with a zero and a negative: min 1 at 3, next 2 at 2 (R1).
        v = '{0, -3, 2, 1};
        for (int k = 0; k < RL; k++) put(v[k], k == 0, k == RL - 1, 1'b1);
        close_row(v, RL, "R1");

        // Restart mid-row: the partial row is thrown away (R7).
        put(1, 1'b1, 1'b0, 1'b1);
        put(1, 1'b0, 1'b0, 1'b1);
        put(3, 1'b1, 1'b0, 1'b1);
        put(2, 1'b0, 1'b1, 1'b1);
        v = '{3, 2, 0, 0};
        close_row(v, 2, "R7");

        // Row with no start marker after a close starts at position 0 (R7).
        put(2, 1'b0, 1'b0, 1'b1);
        put(3, 1'b0, 1'b1, 1'b1);
        v = '{2, 3, 0, 0};
        close_row(v, 2, "R7");

        // Back-to-back rows (R10): row A closes as row B opens.
        put(3, 1'b1, 1'b0, 1'b1);
        put(3, 1'b0, 1'b1, 1'b1);
        put(-1, 1'b1, 1'b0, 1'b1);
        v = '{3, 3, 0, 0};
        compare(v, 2, "R10");
        put(1, 1'b0, 1'b1, 1'b1);
        v = '{-1, 1, 0, 0};
        close_row(v, 2, "R10");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            failed++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

endmodule